// File: doc/BRIEF.md
# Shared-Alphabet Programmable FIR Filter

This block is a ten-tap FIR filter whose coefficients can be rewritten while it runs. It is built in transposed form, so every accepted sample is multiplied by all ten coefficients in the same cycle. The delayed partial sums then flow down a register chain. The block has no general multipliers. One precompute stage forms the eight odd multiples (1x, 3x, ... 15x) of the incoming sample. Each tap builds its product from these shared values. It splits its coefficient magnitude into 4-bit nibbles and maps each nonzero nibble to an odd multiple and a left shift. It then adds the shifted pieces and applies the coefficient sign last.

Samples arrive as 17-bit two's complement values with a valid strobe. Coefficients are 17-bit sign-magnitude words loaded through a write port that takes an address and a data word. The result is the full 37-bit accumulator value in two's complement. It is registered and delivered one cycle after each accepted sample, with no rounding and no saturation.

Top module: `shared_alphabet_fir`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every coefficient and every chain register. While in reset and on the cycle after it, `outValid` is 0 and `yOut` is 0.
- R2: For each accepted sample n, `yOut` = sum over k = 0..9 of c_k · x[n-k]. Here x[n-k] is the k-th earlier accepted sample, with x[n] the current one. c_k is the value tap address k held when x[n-k] was accepted. Samples before reset count as zero.
- R3: `outValid` equals `inValid` of the previous clock cycle. The result for a sample accepted at edge t appears on `yOut` right after edge t.
- R4: While `inValid` is low, the chain does not advance and `yOut` holds its value.
- R5: Coefficients are sign-magnitude. Bit 16 is the sign (1 = negative) and bits 15:0 are the magnitude. A negative zero (17'h10000) acts as zero.
- R6: A coefficient write (`coefWe` high at an edge) takes effect from the next accepted sample. A sample accepted at the same edge as the write still uses the old value.
- R7: A write to an address from 10 to 15 changes no coefficient.
- R8: The output keeps the full sum with no wrap. This holds at the extremes: sample -65536 with magnitude 65535 on all ten taps, for either sign.
- R9: Tap address 0 weights the current sample and address k weights the sample accepted k samples earlier. An impulse therefore reads the coefficients out in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample strobe; the chain advances when high |
| inSample | input | 17 | Two's complement input sample |
| coefWe | input | 1 | Coefficient write enable |
| coefAddr | input | 4 | Tap address of the write |
| coefData | input | 17 | Sign-magnitude coefficient to write |
| outValid | output | 1 | Result valid, one cycle after inValid |
| yOut | output | 37 | Two's complement filter output |

## Verification
A wrong partial sum or coefficient inside the chain shows up at `yOut` as a mismatch within at most ten accepted samples. That is the time it takes the bad value to reach the output register. A fault in the nibble decode of a single tap, or in one precomputed multiple, corrupts the first output that uses that coefficient nibble. Random coefficients hit every odd multiple and every shift quickly. Impulse responses after a load show at once whether writes, ignored addresses or tap ordering are wrong, because each output then isolates one coefficient.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // accept a sample, shift the chain
    logic coefWr;    // a valid in-range coefficient write
    logic clearAll;  // synchronous clear of all state
  } fir_ctrl_t;

endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int TAPS   = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              coefWe,
  input  logic [ADDR_W-1:0] coefAddr,
  output fir_ctrl_t         strobes,
  output logic              outValid
);

  logic addrInRange;

  assign addrInRange = (int'(coefAddr) < TAPS);

  always_comb begin
    strobes.clearAll = rst;
    strobes.advance  = inValid && !rst;
    strobes.coefWr   = coefWe && addrInRange && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/fir_precompute.sv
module fir_precompute #(
  parameter int DATA_W  = 17,
  parameter int NIB_W   = 4,
  localparam int ALPHA_N = 2 ** (NIB_W - 1),
  localparam int PRE_W   = DATA_W + NIB_W
) (
  input  logic signed [DATA_W-1:0]              sampleIn,
  output logic        [ALPHA_N-1:0][PRE_W-1:0]  alphaOut
);

  logic signed [PRE_W-1:0] sampleExt;

  assign sampleExt = PRE_W'(sampleIn);

  for (genvar i = 0; i < ALPHA_N; i++) begin : g_alpha
    localparam int ODD_M = 2 * i + 1;
    logic signed [PRE_W-1:0] sumAcc;
    always_comb begin
      sumAcc = '0;
      for (int b = 0; b < NIB_W; b++) begin
        if (((ODD_M >> b) & 1) == 1) sumAcc = sumAcc + (sampleExt <<< b);
      end
    end
    assign alphaOut[i] = sumAcc;
  end

endmodule

// File: rtl/fir_tap_product.sv
module fir_tap_product #(
  parameter int DATA_W  = 17,
  parameter int COEF_W  = 17,
  parameter int NIB_W   = 4,
  localparam int ALPHA_N = 2 ** (NIB_W - 1),
  localparam int PRE_W   = DATA_W + NIB_W,
  localparam int MAG_W   = COEF_W - 1,
  localparam int NIB_N   = MAG_W / NIB_W,
  localparam int PROD_W  = DATA_W + COEF_W - 1,
  localparam int SH_W    = $clog2(MAG_W)
) (
  input  logic        [ALPHA_N-1:0][PRE_W-1:0] alphaIn,
  input  logic        [COEF_W-1:0]             coefIn,
  output logic signed [PROD_W-1:0]             prodOut
);

  logic signed [PROD_W-1:0] nibTerm [NIB_N];

  for (genvar n = 0; n < NIB_N; n++) begin : g_nib
    logic [NIB_W-1:0] nibVal;
    logic [NIB_W-1:0] oddPart;
    logic [SH_W-1:0]  lowShift;
    logic signed [PROD_W-1:0] picked;

    assign nibVal = coefIn[n*NIB_W +: NIB_W];

    // position of the lowest set bit
    always_comb begin
      lowShift = '0;
      for (int s = NIB_W - 1; s >= 0; s--) begin
        if (nibVal[s]) lowShift = SH_W'(s);
      end
    end

    assign oddPart = nibVal >> lowShift;
    assign picked  = PROD_W'($signed(alphaIn[oddPart[NIB_W-1:1]]));
    assign nibTerm[n] = (nibVal == '0) ? '0
                      : (picked <<< (lowShift + SH_W'(n * NIB_W)));
  end

  logic signed [PROD_W-1:0] magSum;
  logic                     negSign;

  always_comb begin
    magSum = '0;
    for (int n = 0; n < NIB_N; n++) magSum = magSum + nibTerm[n];
  end

  assign negSign = coefIn[COEF_W-1];
  assign prodOut = (magSum ^ {PROD_W{negSign}}) + PROD_W'(negSign);

endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_pkg::*;
#(
  parameter int TAPS   = 10,
  parameter int DATA_W = 17,
  parameter int COEF_W = 17,
  parameter int NIB_W  = 4,
  parameter int GUARD  = 4,
  parameter int ADDR_W = 4,
  localparam int ALPHA_N = 2 ** (NIB_W - 1),
  localparam int PRE_W   = DATA_W + NIB_W,
  localparam int PROD_W  = DATA_W + COEF_W - 1,
  localparam int ACC_W   = PROD_W + GUARD
) (
  input  logic                     clk,
  input  fir_ctrl_t                strobes,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [ADDR_W-1:0]        coefAddr,
  input  logic [COEF_W-1:0]        coefData,
  output logic signed [ACC_W-1:0]  accOut
);

  logic [ALPHA_N-1:0][PRE_W-1:0] alphaBus;
  logic [COEF_W-1:0]             coefReg [TAPS];
  logic signed [PROD_W-1:0]      tapProd [TAPS];
  logic signed [ACC_W-1:0]       partialReg [TAPS];

  fir_precompute #(.DATA_W(DATA_W), .NIB_W(NIB_W)) i_pre (
    .sampleIn (sampleIn),
    .alphaOut (alphaBus)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (strobes.clearAll)
        coefReg[k] <= '0;
      else if (strobes.coefWr && (coefAddr == ADDR_W'(k)))
        coefReg[k] <= coefData;
    end

    fir_tap_product #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NIB_W(NIB_W)) i_prod (
      .alphaIn (alphaBus),
      .coefIn  (coefReg[k]),
      .prodOut (tapProd[k])
    );

    logic signed [ACC_W-1:0] nextPartial;
    if (k == TAPS - 1) begin : g_last
      assign nextPartial = ACC_W'(tapProd[k]);
    end else begin : g_mid
      assign nextPartial = ACC_W'(tapProd[k]) + partialReg[k+1];
    end

    always_ff @(posedge clk) begin
      if (strobes.clearAll)     partialReg[k] <= '0;
      else if (strobes.advance) partialReg[k] <= nextPartial;
    end
  end

  assign accOut = partialReg[0];

endmodule

// File: rtl/shared_alphabet_fir.sv
module shared_alphabet_fir
  import fir_pkg::*;
#(
  parameter int TAPS   = 10,
  parameter int DATA_W = 17,
  parameter int COEF_W = 17,
  parameter int NIB_W  = 4,
  parameter int GUARD  = 4,
  localparam int ADDR_W = $clog2(TAPS),
  localparam int ACC_W  = DATA_W + COEF_W - 1 + GUARD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inSample,
  input  logic              coefWe,
  input  logic [ADDR_W-1:0] coefAddr,
  input  logic [COEF_W-1:0] coefData,
  output logic              outValid,
  output logic [ACC_W-1:0]  yOut
);

  fir_ctrl_t ctrlStrobes;
  logic signed [ACC_W-1:0] accValue;

  fir_ctrl #(.TAPS(TAPS), .ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .strobes  (ctrlStrobes),
    .outValid (outValid)
  );

  fir_datapath #(
    .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .NIB_W(NIB_W), .GUARD(GUARD), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk      (clk),
    .strobes  (ctrlStrobes),
    .sampleIn ($signed(inSample)),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .accOut   (accValue)
  );

  assign yOut = accValue;

endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
  parameter int ACC_W = 37
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [ACC_W-1:0] yOut
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && yOut == '0));

  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_idle_follows_R3: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(yOut));

endmodule

bind shared_alphabet_fir fir_checker #(.ACC_W(ACC_W)) i_fir_checker (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .yOut     (yOut)
);

// File: tb/test_shared_alphabet_fir.sv
module test_shared_alphabet_fir;

  localparam int TAPS = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [16:0] inSample;
  logic        coefWe;
  logic [3:0]  coefAddr;
  logic [16:0] coefData;
  logic        outValid;
  logic [36:0] yOut;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [16:0] mirror [TAPS];
  logic [16:0] snap   [TAPS][TAPS];
  longint      xs     [TAPS];
  longint      expY   = 0;

  shared_alphabet_fir i_shared_alphabet_fir (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .yOut(yOut)
  );

  always #5ns clk = ~clk;

  function automatic longint coefVal(input logic [16:0] c);
    longint m = longint'(c[15:0]);
    return c[16] ? -m : m;
  endfunction

  function automatic longint sampVal(input logic [16:0] s);
    return longint'($signed(s));
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int k = 0; k < TAPS; k++) begin
      mirror[k] = '0;
      xs[k] = 0;
      for (int j = 0; j < TAPS; j++) snap[k][j] = '0;
    end
    expY = 0;
  endtask

  // one clock: drive at negedge, check just after the posedge
  task automatic step(input bit v, input logic [16:0] x, input bit we,
                      input logic [3:0] a, input logic [16:0] d, input string tag);
    @(negedge clk);
    inValid = v; inSample = x; coefWe = we; coefAddr = a; coefData = d;
    @(posedge clk);
    #1ns;
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) begin
        xs[k] = xs[k-1];
        for (int j = 0; j < TAPS; j++) snap[k][j] = snap[k-1][j];
      end
      xs[0] = sampVal(x);
      for (int j = 0; j < TAPS; j++) snap[0][j] = mirror[j];
      expY = 0;
      for (int k = 0; k < TAPS; k++) expY += coefVal(snap[k][k]) * xs[k];
    end
    if (we && int'(a) < TAPS) mirror[a] = d;
    check(outValid == v, {tag, " R3 outValid"}, longint'(outValid), longint'(v));
    check(longint'($signed(yOut)) == expY, {tag, " yOut"},
          longint'($signed(yOut)), expY);
  endtask

  task automatic loadAll(input logic [16:0] c [TAPS]);
    for (int k = 0; k < TAPS; k++) step(0, '0, 1, 4'(k), c[k], "R6 load");
  endtask

  task automatic flush();
    for (int k = 0; k < TAPS; k++) step(1, '0, 0, '0, '0, "R2 flush");
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [16:0] cset [TAPS];
    void'($urandom(32'd2024));
    rst = 1; inValid = 0; inSample = '0; coefWe = 0; coefAddr = '0; coefData = '0;
    clearModel();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(outValid == 0, "R1 outValid after reset", longint'(outValid), 0);
    check(yOut == '0, "R1 yOut after reset", longint'($signed(yOut)), 0);
    // R1: coefficients cleared, so samples give zero
    step(1, 17'h01234, 0, '0, '0, "R1 zero coefs");
    step(1, 17'h1ff00, 0, '0, '0, "R1 zero coefs");

    // R9: impulse reads coefficients back in address order
    for (int k = 0; k < TAPS; k++) cset[k] = 17'(100 * (k + 1)) | (k[0] ? 17'h10000 : 17'h0);
    loadAll(cset);
    flush();
    step(1, 17'd1, 0, '0, '0, "R9 impulse");
    for (int k = 1; k < TAPS; k++) step(1, '0, 0, '0, '0, "R9 impulse tail");

    // R4: idle cycles hold the output
    step(1, 17'd7, 0, '0, '0, "R4 before idle");
    for (int k = 0; k < 4; k++) step(0, 17'h15555, 0, '0, '0, "R4 idle hold");

    // R5: negative zero acts as zero
    step(0, '0, 1, 4'd0, 17'h10000, "R5 load");
    flush();
    step(1, 17'd999, 0, '0, '0, "R5 negative zero");

    // R6: write and sample at the same edge, old value applies
    step(0, '0, 1, 4'd0, 17'd3, "R6 load");
    flush();
    step(1, 17'd50, 1, 4'd0, 17'd11, "R6 same edge");
    step(1, 17'd50, 0, '0, '0, "R6 next sample");

    // R7: out-of-range addresses change nothing
    for (int a = 10; a < 16; a++) step(0, '0, 1, 4'(a), 17'h0ffff, "R7 ignored write");
    flush();
    step(1, 17'd1, 0, '0, '0, "R7 impulse");
    for (int k = 1; k < TAPS; k++) step(1, '0, 0, '0, '0, "R7 impulse tail");

    // R8: extremes, both signs
    for (int k = 0; k < TAPS; k++) cset[k] = 17'h0ffff;
    loadAll(cset);
    for (int k = 0; k < TAPS + 1; k++) step(1, 17'h10000, 0, '0, '0, "R8 max positive coef");
    for (int k = 0; k < TAPS; k++) cset[k] = 17'h1ffff;
    loadAll(cset);
    for (int k = 0; k < TAPS + 1; k++) step(1, 17'h10000, 0, '0, '0, "R8 max negative coef");
    for (int k = 0; k < TAPS + 1; k++) step(1, 17'h0ffff, 0, '0, '0, "R8 max sample");

    // R2: constrained random mix
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 4) != 0;
      bit we = ($urandom % 6) == 0;
      logic [3:0] a = 4'($urandom % 16);
      logic [16:0] d = 17'($urandom);
      logic [16:0] x = 17'($urandom);
      if ($urandom % 8 == 0) x = ($urandom % 2) ? 17'h10000 : 17'h0ffff;
      step(v, x, we, a, d, "R2 random");
    end

    // R1: reset mid-stream clears coefficients and chain
    @(negedge clk);
    rst = 1; inValid = 0; coefWe = 0;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    clearModel();
    check(yOut == '0, "R1 yOut after second reset", longint'($signed(yOut)), 0);
    step(1, 17'd12345, 0, '0, '0, "R1 coefs cleared");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule